// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block brings up four point-of-load converter rails in a programmed order and takes them down in the opposite order. It drives one enable per rail. For each rail it receives a digitized voltage sample and a power-good comparator bit.

After a start request the block enables the rail in slot 0. It then waits until that rail's sample reaches the rail's interlock threshold. It holds for a settle delay, and only then enables the rail in slot 1, and so on through the last slot. If a rail never reaches its threshold within the step timeout, the sequence stops there, and the rails already enabled are switched off from the last slot back to slot 0. A stop request causes the same orderly reverse shutdown; the stop input is also the one to drive when input power is lost or the card is being removed. A power-good loss on a rail that has already qualified also causes it.

Shutdown steps are spaced by a programmable delay. A shutdown caused by a fault ends in a held fault state that reports the failing rail. That state is left only by a clear request once every power-good input reads low.

Configuration uses a valid/ready write port. A write completes on a cycle with `cfg_valid` and `cfg_ready` both high, so the writer holds address and data until then. The block applies back-pressure by keeping `cfg_ready` low for the whole active sequence. The start, stop and clear inputs, and the status outputs, are plain signals.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After start, rails are enabled one at a time in slot order 0,1,2,3, where slot k holds the rail index written to config address k. The status code on `st_state` is 0 idle, 1 ramping up, 2 all on, 3 ramping down, 4 fault.
- R2: The rail of slot k+1 is enabled exactly up_delay+1 cycles after the first clock edge at which the slot-k rail's sample is at or above that rail's threshold. The threshold of rail r is at config address 4+r. A rail whose threshold is never reached blocks all later slots.
- R3: A stop request while ramping up or all on disables the enabled rails in reverse slot order, one per step and never two in one cycle. With all rails off the block returns to idle.
- R4: During shutdown, consecutive rail disables are exactly down_delay+1 cycles apart. down_delay is at config address 10.
- R5: A rail that does not reach its threshold is disabled timeout+1 cycles after it was enabled. timeout is at config address 8. No later slot is enabled, and `st_fail` reports that rail's index.
- R6: A shutdown caused by a fault runs in reverse slot order from the failing step. It enables no rail while it runs and ends in state 4 with every enable low.
- R7: Power-good going low on a rail that has already qualified starts a fault shutdown. A rail has qualified if it is in an earlier slot during ramp-up, or is any rail while all are on. `st_fail` gives the lowest such rail index.
- R8: A stop request during ramp-up abandons the sequence. The rails enabled so far are disabled in reverse order, and the block ends idle rather than in fault.
- R9: The fault state ignores start. It goes to idle only on a clear request made while all power-good inputs are low.
- R10: `cfg_ready` is high only in idle and fault states. up_delay is at config address 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Begin the power-up sequence |
| stop_req | input | 1 | Orderly shutdown; also for power loss or card removal |
| clear_req | input | 1 | Leave the fault state |
| cfg_valid | input | 1 | Configuration write valid |
| cfg_ready | output | 1 | Configuration write accepted this cycle |
| cfg_addr | input | 4 | Configuration register address |
| cfg_data | input | 8 | Configuration write data |
| rail_adc | input | 32 | Per-rail voltage samples, rail r in bits 8r+7:8r |
| rail_pg | input | 4 | Per-rail power-good comparator |
| rail_en | output | 4 | Per-rail converter enable |
| st_state | output | 3 | Sequencer state code |
| st_step | output | 2 | Current slot index |
| st_fail | output | 2 | Index of the rail that caused the last fault |

## Verification
Some properties are checked on every cycle: at most one enable rises per cycle and at most one falls; no enable rises during shutdown; all enables are low in idle and fault; the fault state is left only after a clear with all power-good low; and configuration is refused while a sequence runs. Other behaviour appears only in the bench scenarios. These cover the actual slot order across all 24 orderings, the exact settle and shutdown spacing, the timeout length, the reported failing rail, and the choice between ending idle and ending in fault.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_UP    = 3'd1,
    ST_ON    = 3'd2,
    ST_DOWN  = 3'd3,
    ST_FAULT = 3'd4
  } seq_st_e;
endpackage

// File: rtl/pwrseq_cfg.sv
module pwrseq_cfg #(
  parameter int NR      = 4,
  parameter int AW      = 8,
  parameter int TW      = 8,
  parameter int DW      = 8,
  parameter int IW      = 2,
  parameter int CAW     = 4,
  parameter int THR_DEF = 160,
  parameter int TMO_DEF = 40,
  parameter int UPD_DEF = 3,
  parameter int DND_DEF = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    open_i,
  input  logic                    cfg_valid,
  output logic                    cfg_ready,
  input  logic [CAW-1:0]          cfg_addr,
  input  logic [DW-1:0]           cfg_data,
  output logic [NR-1:0][IW-1:0]   order_o,
  output logic [NR-1:0][AW-1:0]   thr_o,
  output logic [TW-1:0]           tmo_o,
  output logic [TW-1:0]           upd_o,
  output logic [TW-1:0]           dnd_o
);
  localparam int A_THR = NR;
  localparam int A_TMO = 2 * NR;
  localparam int A_UPD = 2 * NR + 1;
  localparam int A_DND = 2 * NR + 2;

  logic take;
  assign cfg_ready = open_i;
  assign take      = cfg_valid && open_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NR; k++) begin
        order_o[k] <= IW'(k);
        thr_o[k]   <= AW'(THR_DEF);
      end
      tmo_o <= TW'(TMO_DEF);
      upd_o <= TW'(UPD_DEF);
      dnd_o <= TW'(DND_DEF);
    end else if (take) begin
      for (int k = 0; k < NR; k++) begin
        if (cfg_addr == CAW'(k))         order_o[k] <= cfg_data[IW-1:0];
        if (cfg_addr == CAW'(A_THR + k)) thr_o[k]   <= cfg_data[AW-1:0];
      end
      if (cfg_addr == CAW'(A_TMO)) tmo_o <= cfg_data[TW-1:0];
      if (cfg_addr == CAW'(A_UPD)) upd_o <= cfg_data[TW-1:0];
      if (cfg_addr == CAW'(A_DND)) dnd_o <= cfg_data[TW-1:0];
    end
  end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [TW-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_o <= '0;
    else if (clr_i)          cnt_o <= '0;
    else if (cnt_o != '1)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pwrseq_map.sv
module pwrseq_map #(
  parameter int NR = 4,
  parameter int IW = 2
) (
  input  logic [NR-1:0][IW-1:0] order_i,
  input  logic [NR-1:0]         slot_on_i,
  input  logic [NR-1:0]         slot_mon_i,
  input  logic [NR-1:0]         rail_pg_i,
  output logic [NR-1:0]         rail_en_o,
  output logic                  bad_o,
  output logic [IW-1:0]         bad_idx_o
);
  logic [NR-1:0] mon_rail;
  logic [NR-1:0] bad;

  for (genvar r = 0; r < NR; r++) begin : g_rail
    logic en_r, mon_r;
    always_comb begin
      en_r  = 1'b0;
      mon_r = 1'b0;
      for (int j = 0; j < NR; j++) begin
        if (order_i[j] == IW'(r)) begin
          en_r  = en_r  | slot_on_i[j];
          mon_r = mon_r | slot_mon_i[j];
        end
      end
    end
    assign rail_en_o[r] = en_r;
    assign mon_rail[r]  = mon_r;
  end

  assign bad   = mon_rail & ~rail_pg_i;
  assign bad_o = |bad;

  always_comb begin
    bad_idx_o = '0;
    for (int r = NR - 1; r >= 0; r--) begin
      if (bad[r]) bad_idx_o = IW'(r);
    end
  end
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int NR = 4,
  parameter int AW = 8,
  parameter int TW = 8,
  parameter int IW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  clear_i,
  input  logic [NR*AW-1:0]      rail_adc_i,
  input  logic [NR-1:0]         rail_pg_i,
  input  logic [NR-1:0][IW-1:0] order_i,
  input  logic [NR-1:0][AW-1:0] thr_i,
  input  logic [TW-1:0]         tmo_i,
  input  logic [TW-1:0]         upd_i,
  input  logic [TW-1:0]         dnd_i,
  input  logic                  bad_i,
  input  logic [IW-1:0]         bad_idx_i,
  input  logic [TW-1:0]         cnt_i,
  output logic                  clr_o,
  output logic [NR-1:0]         slot_on_o,
  output logic [NR-1:0]         slot_mon_o,
  output logic                  cfg_open_o,
  output seq_st_e               state_o,
  output logic [IW-1:0]         step_o,
  output logic [IW-1:0]         fail_o
);
  localparam logic [IW-1:0] LAST = IW'(NR - 1);

  seq_st_e       state, nxt;
  logic [IW-1:0] step, step_n, fail, fail_n;
  logic          reached, reach_n, flt, flt_n;
  logic [IW-1:0] cur_rail;
  logic [AW-1:0] cur_adc;
  logic          crossed;

  assign cur_rail = order_i[step];
  assign cur_adc  = rail_adc_i[int'(cur_rail) * AW +: AW];
  assign crossed  = cur_adc >= thr_i[cur_rail];

  always_comb begin
    nxt = state; step_n = step; reach_n = reached;
    flt_n = flt; fail_n = fail; clr_o = 1'b0;
    unique case (state)
      ST_IDLE: if (start_i) begin
        nxt = ST_UP; step_n = '0; reach_n = 1'b0; flt_n = 1'b0; clr_o = 1'b1;
      end
      ST_UP: begin
        if (bad_i) begin
          nxt = ST_DOWN; flt_n = 1'b1; fail_n = bad_idx_i; clr_o = 1'b1;
        end else if (stop_i) begin
          nxt = ST_DOWN; clr_o = 1'b1;
        end else if (!reached) begin
          if (crossed) begin
            reach_n = 1'b1; clr_o = 1'b1;
          end else if (cnt_i >= tmo_i) begin
            nxt = ST_DOWN; flt_n = 1'b1; fail_n = cur_rail; clr_o = 1'b1;
          end
        end else if (cnt_i >= upd_i) begin
          clr_o = 1'b1; reach_n = 1'b0;
          if (step == LAST) nxt = ST_ON;
          else              step_n = step + 1'b1;
        end
      end
      ST_ON: begin
        if (bad_i) begin
          nxt = ST_DOWN; step_n = LAST; flt_n = 1'b1; fail_n = bad_idx_i; clr_o = 1'b1;
        end else if (stop_i) begin
          nxt = ST_DOWN; step_n = LAST; clr_o = 1'b1;
        end
      end
      ST_DOWN: if (cnt_i >= dnd_i) begin
        clr_o = 1'b1;
        if (step == '0) nxt = flt ? ST_FAULT : ST_IDLE;
        else            step_n = step - 1'b1;
      end
      ST_FAULT: if (clear_i && (rail_pg_i == '0)) begin
        nxt = ST_IDLE; flt_n = 1'b0;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; step <= '0; fail <= '0; reached <= 1'b0; flt <= 1'b0;
    end else begin
      state <= nxt; step <= step_n; fail <= fail_n; reached <= reach_n; flt <= flt_n;
    end
  end

  always_comb begin
    for (int j = 0; j < NR; j++) begin
      slot_on_o[j]  = ((state == ST_UP) && (IW'(j) <= step)) || (state == ST_ON) ||
                      ((state == ST_DOWN) && (IW'(j) < step));
      slot_mon_o[j] = ((state == ST_UP) && (IW'(j) < step)) || (state == ST_ON);
    end
  end

  assign cfg_open_o = (state == ST_IDLE) || (state == ST_FAULT);
  assign state_o    = state;
  assign step_o     = step;
  assign fail_o     = fail;
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NR      = 4,
  parameter int AW      = 8,
  parameter int TW      = 8,
  parameter int DW      = 8,
  parameter int THR_DEF = 160,
  parameter int TMO_DEF = 40,
  parameter int UPD_DEF = 3,
  parameter int DND_DEF = 6,
  localparam int IW     = $clog2(NR),
  localparam int CAW    = $clog2(2 * NR + 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               stop_req,
  input  logic               clear_req,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [CAW-1:0]     cfg_addr,
  input  logic [DW-1:0]      cfg_data,
  input  logic [NR*AW-1:0]   rail_adc,
  input  logic [NR-1:0]      rail_pg,
  output logic [NR-1:0]      rail_en,
  output logic [2:0]         st_state,
  output logic [IW-1:0]      st_step,
  output logic [IW-1:0]      st_fail
);
  logic [NR-1:0][IW-1:0] order;
  logic [NR-1:0][AW-1:0] thr;
  logic [TW-1:0]         tmo, upd, dnd, cnt;
  logic                  cfg_open, clr, bad;
  logic [IW-1:0]         bad_idx;
  logic [NR-1:0]         slot_on, slot_mon;
  seq_st_e               state;

  pwrseq_cfg #(
    .NR(NR), .AW(AW), .TW(TW), .DW(DW), .IW(IW), .CAW(CAW),
    .THR_DEF(THR_DEF), .TMO_DEF(TMO_DEF), .UPD_DEF(UPD_DEF), .DND_DEF(DND_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .open_i(cfg_open), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .order_o(order), .thr_o(thr), .tmo_o(tmo), .upd_o(upd), .dnd_o(dnd)
  );

  pwrseq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .cnt_o(cnt)
  );

  pwrseq_fsm #(.NR(NR), .AW(AW), .TW(TW), .IW(IW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_req), .stop_i(stop_req),
    .clear_i(clear_req), .rail_adc_i(rail_adc), .rail_pg_i(rail_pg),
    .order_i(order), .thr_i(thr), .tmo_i(tmo), .upd_i(upd), .dnd_i(dnd),
    .bad_i(bad), .bad_idx_i(bad_idx), .cnt_i(cnt), .clr_o(clr),
    .slot_on_o(slot_on), .slot_mon_o(slot_mon), .cfg_open_o(cfg_open),
    .state_o(state), .step_o(st_step), .fail_o(st_fail)
  );

  pwrseq_map #(.NR(NR), .IW(IW)) u_map (
    .order_i(order), .slot_on_i(slot_on), .slot_mon_i(slot_mon),
    .rail_pg_i(rail_pg), .rail_en_o(rail_en), .bad_o(bad), .bad_idx_o(bad_idx)
  );

  assign st_state = state;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int NR = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear_req,
  input logic          cfg_ready,
  input logic [NR-1:0] rail_pg,
  input logic [NR-1:0] rail_en,
  input logic [2:0]    st_state
);
  // R1: enables come up one at a time
  assert_one_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rail_en & ~$past(rail_en)));

  // R3: enables go down one at a time
  assert_one_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~rail_en & $past(rail_en)));

  // R6: no rail is switched on while shutting down
  assert_quiet_shutdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_state == 3'd3) |=> ((rail_en & ~$past(rail_en)) == '0));

  // R6: resting states hold every rail off
  assert_rest_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_state == 3'd0) || (st_state == 3'd4)) |-> (rail_en == '0));

  // R9: fault left only by clear with all power-good low, and only to idle
  assert_fault_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_state) == 3'd4) && (st_state != 3'd4)) |->
      ($past(clear_req) && ($past(rail_pg) == '0) && (st_state == 3'd0)));

  // R10: configuration refused while a sequence runs
  assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_state == 3'd1) || (st_state == 3'd2) || (st_state == 3'd3)) |-> !cfg_ready);
endmodule

bind pwrseq_ctrl pwrseq_chk #(.NR(NR)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .cfg_ready(cfg_ready),
  .rail_pg(rail_pg), .rail_en(rail_en), .st_state(st_state)
);

// File: tb/pwrseq_ctrl_bench.sv
`timescale 1ns/1ps
module pwrseq_ctrl_bench;
  localparam int NR = 4, AW = 8, IW = 2, CAW = 4;
  localparam int TMO = 40, UPD = 3, DND = 6, FULL = 200, RATE = 25, PGL = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, stop_req = 1'b0, clear_req = 1'b0;
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic [CAW-1:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic [NR*AW-1:0] rail_adc;
  logic [NR-1:0] rail_pg, rail_en;
  logic [2:0] st_state;
  logic [IW-1:0] st_step, st_fail;

  logic [AW-1:0] adc [NR];
  logic [NR-1:0] dead = '0, drop = '0, hold_hi = '0;
  int thr_b [NR];
  int cross_cyc [NR];
  int up_rail [8], up_cyc [8], dn_rail [8], dn_cyc [8];
  int up_n = 0, dn_n = 0, cyc = 0;
  int vec = 0, bad = 0;
  logic [NR-1:0] prev_en = '0;

  always #4 clk = ~clk;

  pwrseq_ctrl u_pwrseq_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .clear_req(clear_req), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .rail_adc(rail_adc),
    .rail_pg(rail_pg), .rail_en(rail_en), .st_state(st_state),
    .st_step(st_step), .st_fail(st_fail)
  );

  for (genvar r = 0; r < NR; r++) begin : g_pack
    assign rail_adc[r*AW +: AW] = adc[r];
    assign rail_pg[r] = ((int'(adc[r]) >= PGL) && !drop[r]) || hold_hi[r];
  end

  // converter model and enable logger, both on the falling edge
  initial begin
    for (int r = 0; r < NR; r++) begin adc[r] = '0; thr_b[r] = 160; cross_cyc[r] = 0; end
    forever begin
      @(negedge clk);
      cyc++;
      for (int r = 0; r < NR; r++) begin
        int ov, nv;
        ov = int'(adc[r]);
        if (rail_en[r] && !dead[r]) nv = (ov + RATE > FULL) ? FULL : ov + RATE;
        else                        nv = (ov >= RATE) ? ov - RATE : 0;
        if (ov < thr_b[r] && nv >= thr_b[r]) cross_cyc[r] = cyc;
        adc[r] = AW'(nv);
        if (rail_en[r] && !prev_en[r] && up_n < 8) begin up_rail[up_n] = r; up_cyc[up_n] = cyc; up_n++; end
        if (!rail_en[r] && prev_en[r] && dn_n < 8) begin dn_rail[dn_n] = r; dn_cyc[dn_n] = cyc; dn_n++; end
      end
      prev_en = rail_en;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input int d);
    @(negedge clk); cfg_valid = 1'b1; cfg_addr = CAW'(a); cfg_data = 8'(d);
    @(negedge clk); cfg_valid = 1'b0;
  endtask

  task automatic do_start; @(negedge clk); start_req = 1'b1; @(negedge clk); start_req = 1'b0; endtask
  task automatic do_stop;  @(negedge clk); stop_req  = 1'b1; @(negedge clk); stop_req  = 1'b0; endtask
  task automatic do_clear; @(negedge clk); clear_req = 1'b1; @(negedge clk); clear_req = 1'b0; endtask
  task automatic settle; repeat (14) @(negedge clk); endtask
  task automatic clear_logs; #1; up_n = 0; dn_n = 0; endtask

  task automatic wait_state(input int code, input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (int'(st_state) == code) break;
    end
    #1;
  endtask

  task automatic set_order(input int s0, input int s1, input int s2, input int s3);
    cfg_write(0, s0); cfg_write(1, s1); cfg_write(2, s2); cfg_write(3, s3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog (all requirements): got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(st_state == 3'd0, "R1 reset idle", int'(st_state), 0);
    check(rail_en == '0, "R3 reset enables", int'(rail_en), 0);
    check(cfg_ready == 1'b1, "R10 reset ready", int'(cfg_ready), 1);

    cfg_write(8, TMO); cfg_write(9, UPD); cfg_write(10, DND);
    for (int r = 0; r < NR; r++) cfg_write(4 + r, 160);

    // every startup order
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        if (b == a) continue;
        for (int c = 0; c < 4; c++) begin
          if (c == a || c == b) continue;
          for (int d = 0; d < 4; d++) begin
            int p [4];
            if (d == a || d == b || d == c) continue;
            p[0] = a; p[1] = b; p[2] = c; p[3] = d;
            set_order(a, b, c, d);
            clear_logs();
            do_start();
            wait_state(2, 400);
            check(st_state == 3'd2, "R1 reached on", int'(st_state), 2);
            check(up_n == 4, "R1 enable count", up_n, 4);
            for (int j = 0; j < 4; j++)
              check(up_rail[j] == p[j], "R1 startup order", up_rail[j], p[j]);
            for (int j = 1; j < 4; j++)
              check(up_cyc[j] - cross_cyc[p[j-1]] == UPD + 2, "R2 interlock spacing",
                    up_cyc[j] - cross_cyc[p[j-1]], UPD + 2);
            check(cfg_ready == 1'b0, "R10 locked while on", int'(cfg_ready), 0);
            do_stop();
            wait_state(0, 400);
            check(dn_n == 4, "R3 disable count", dn_n, 4);
            for (int j = 0; j < 4; j++)
              check(dn_rail[j] == p[3-j], "R3 reverse order", dn_rail[j], p[3-j]);
            for (int j = 1; j < 4; j++)
              check(dn_cyc[j] - dn_cyc[j-1] == DND + 1, "R4 shutdown spacing",
                    dn_cyc[j] - dn_cyc[j-1], DND + 1);
            check(rail_en == '0, "R3 all off", int'(rail_en), 0);
            settle();
          end
        end
      end

    // a rail that never comes up, in each slot
    set_order(0, 1, 2, 3);
    for (int s = 0; s < 4; s++) begin
      dead[s] = 1'b1;
      clear_logs();
      do_start();
      wait_state(4, 600);
      check(int'(st_fail) == s, "R5 failing rail", int'(st_fail), s);
      check(up_n == s + 1, "R5 later slots held", up_n, s + 1);
      check(dn_cyc[0] - up_cyc[s] == TMO + 1, "R5 timeout length", dn_cyc[0] - up_cyc[s], TMO + 1);
      check(dn_n == s + 1, "R6 disable count", dn_n, s + 1);
      for (int j = 0; j <= s; j++)
        check(dn_rail[j] == s - j, "R6 reverse order", dn_rail[j], s - j);
      check(st_state == 3'd4, "R6 fault state", int'(st_state), 4);
      check(rail_en == '0, "R6 all off", int'(rail_en), 0);
      do_start();
      repeat (5) @(negedge clk); #1;
      check(st_state == 3'd4 && rail_en == '0, "R9 start ignored", int'(st_state), 4);
      dead[s] = 1'b0;
      settle();
      do_clear();
      repeat (2) @(negedge clk); #1;
      check(st_state == 3'd0, "R9 clear to idle", int'(st_state), 0);
    end

    // power-good lost on each rail while all on
    for (int r = 0; r < 4; r++) begin
      clear_logs();
      do_start();
      wait_state(2, 400);
      @(negedge clk); drop[r] = 1'b1;
      wait_state(4, 400);
      check(int'(st_fail) == r, "R7 failing rail", int'(st_fail), r);
      check(dn_n == 4, "R7 all disabled", dn_n, 4);
      check(dn_rail[0] == 3, "R6 last slot first", dn_rail[0], 3);
      check(rail_en == '0, "R6 all off", int'(rail_en), 0);
      drop[r] = 1'b0;
      settle();
      hold_hi[(r + 1) % 4] = 1'b1;
      do_clear();
      repeat (3) @(negedge clk); #1;
      check(st_state == 3'd4, "R9 clear blocked by power-good", int'(st_state), 4);
      hold_hi = '0;
      do_clear();
      repeat (2) @(negedge clk); #1;
      check(st_state == 3'd0, "R9 clear to idle", int'(st_state), 0);
    end

    // stop part way through startup
    clear_logs();
    do_start();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (up_n >= 2) break;
    end
    do_stop();
    wait_state(0, 300);
    check(dn_n == 2, "R8 disable count", dn_n, 2);
    check(dn_rail[0] == 1, "R8 reverse first", dn_rail[0], 1);
    check(dn_rail[1] == 0, "R8 reverse second", dn_rail[1], 0);
    check(st_state == 3'd0, "R8 ends idle", int'(st_state), 0);
    settle();

    // unreachable threshold on rail 0
    cfg_write(4, 250); thr_b[0] = 250;
    clear_logs();
    do_start();
    wait_state(4, 600);
    check(int'(st_fail) == 0, "R2 threshold blocks", int'(st_fail), 0);
    check(up_n == 1, "R2 next slot held", up_n, 1);
    check(cfg_ready == 1'b1, "R10 open in fault", int'(cfg_ready), 1);
    cfg_write(4, 160); thr_b[0] = 160;
    settle();
    do_clear();
    repeat (2) @(negedge clk); #1;
    check(st_state == 3'd0, "R9 clear to idle", int'(st_state), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule